// File: doc/BRIEF.md
# Zoned Disk Address Translator

This block turns a logical block address into the physical place where that block sits on a zoned, multi-head disk. The result is a cylinder, a head and a rotational slot. A request is accepted through a valid/ready handshake. Some cycles later a one-cycle response gives either the physical tuple or an out-of-range error.

The address path runs in a fixed order. First comes a capacity check. Next is a lookup in a run-time remap table for defects found in the field. If the lookup misses, factory-slipped bad positions are skipped. The resulting physical linear position is then located in a zone table that is walked from the outermost zone inward. A serial divider splits the position into a track and a sector index. A second pass of the divider applies the per-track and per-head skew modulo the zone's track length. The zone table, the factory slip list and the skews are elaboration parameters. The remap table has a write port, so firmware can load entries while the block is working.

Top module: `lba_xlat`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the response. `rsp_valid` is a single-cycle pulse, and in the cycle after it `req_ready` is 1 again.
- R3: The capacity is the total number of physical sectors minus the number of factory-slipped positions (286 with the default geometry). An address at or above the capacity gives `rsp_err`=1 with cylinder, head and slot all 0.
- R4: A physical linear position is located by walking the zones in ascending starting-cylinder order. Each zone holds (end cylinder − start cylinder) × sectors-per-track × heads positions, and the last zone ends at `TOTAL_CYLS`. Inside a zone, track = offset / spt and sector = offset mod spt. The cylinder is the zone start plus track / heads, and the head is track mod heads. The default zones start at cylinders 0, 4, 8 and 12, with 12, 10, 8 and 6 sectors per track and 2 heads.
- R5: Factory slipping works from an ascending list of bad physical linear positions (default 5 and 100). Logical address L maps to the (L+1)-th good position, so every bad position at or below the target shifts it up by one.
- R6: The reported slot is (sector + cylinder × zone track skew + head × `HEAD_SKEW`) mod the zone's sectors per track. The default track skews are 3, 2, 2 and 1, and `HEAD_SKEW` is 1.
- R7: A write on the remap port stores the enable, logical address, cylinder, head and slot in entry `remap_idx`. On an enabled entry whose address matches the request, that entry's tuple is returned in place of the computed one. When several entries match, the lowest index wins. Writing an entry with enable 0 removes it.
- R8: The range check comes before the remap lookup. An out-of-range address gives an error even if an enabled remap entry matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to take a request |
| req_lba | input | 16 | Logical block address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Address beyond capacity |
| rsp_cyl | output | 8 | Physical cylinder |
| rsp_head | output | 1 | Physical head |
| rsp_slot | output | 6 | Rotational slot on the track |
| remap_we | input | 1 | Remap entry write strobe |
| remap_idx | input | 4 | Remap entry index |
| remap_en | input | 1 | Enable bit written into the entry |
| remap_lba | input | 16 | Logical address the entry redirects |
| remap_cyl | input | 8 | Spare cylinder |
| remap_head | input | 1 | Spare head |
| remap_slot | input | 6 | Spare slot |

## Verification
The assertions check the handshake rules on every cycle. They check that error responses carry all-zero fields, and that slipping never moves a position by more than the slip-list length. They check that each computed response lands inside the zone it was taken from, and that every divider result satisfies quotient × divisor + remainder = dividend with the remainder below the divisor. Whether the zone walk, the slip shift and the skew rotation give the right tuple for a given address can only be shown by the bench. It sweeps every address of the default geometry past the capacity limit and compares each result with an arithmetic model. The remap table's priority, its removal and the ordering of the range check against a remap entry are likewise only shown by directed bench scenarios.

// File: rtl/lba_xlat_pkg.sv
package lba_xlat_pkg;

    localparam int LBA_W  = 16;
    localparam int CYL_W  = 8;
    localparam int HEAD_W = 1;
    localparam int SPT_W  = 6;
    localparam int SKEW_W = 4;

    localparam int PROD_W = CYL_W + SKEW_W + 2;
    localparam int DIV_W  = (LBA_W > PROD_W) ? LBA_W : PROD_W;

    typedef struct packed {
        logic [CYL_W-1:0]  cyl;
        logic [HEAD_W-1:0] head;
        logic [SPT_W-1:0]  slot;
    } chs_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SLIP,
        ST_ZONE,
        ST_DIV_TRK,
        ST_DIV_SLOT,
        ST_DONE
    } xlat_state_e;

    // Unreduced rotational position before the modulo by track length.
    function automatic logic [DIV_W-1:0] skewed_pos(
        input logic [SPT_W-1:0]  sec,
        input logic [CYL_W-1:0]  cyl,
        input logic [SKEW_W-1:0] trk_skew,
        input logic [HEAD_W-1:0] head,
        input logic [SKEW_W-1:0] hd_skew
    );
        return DIV_W'(sec)
             + DIV_W'(cyl)  * DIV_W'(trk_skew)
             + DIV_W'(head) * DIV_W'(hd_skew);
    endfunction

endpackage

// File: rtl/xlat_zone_table.sv
module xlat_zone_table
    import lba_xlat_pkg::*;
#(
    parameter int NUM_ZONES  = 4,
    parameter int TOTAL_CYLS = 16,
    parameter logic [NUM_ZONES*CYL_W-1:0]  ZONE_START = '0,
    parameter logic [NUM_ZONES*SPT_W-1:0]  ZONE_SPT   = '0,
    parameter logic [NUM_ZONES*SKEW_W-1:0] ZONE_SKEW  = '0,
    localparam int ZI_W = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
    input  logic [ZI_W-1:0]   idx,
    output logic [CYL_W-1:0]  z_start,
    output logic [SPT_W-1:0]  z_spt,
    output logic [SKEW_W-1:0] z_skew,
    output logic [LBA_W:0]    z_size
);

    localparam int HEADS = 1 << HEAD_W;

    logic [CYL_W-1:0]  start_a [NUM_ZONES];
    logic [CYL_W:0]    end_a   [NUM_ZONES];
    logic [SPT_W-1:0]  spt_a   [NUM_ZONES];
    logic [SKEW_W-1:0] skew_a  [NUM_ZONES];
    logic [LBA_W:0]    size_a  [NUM_ZONES];

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        assign start_a[z] = ZONE_START[z*CYL_W +: CYL_W];
        assign spt_a[z]   = ZONE_SPT[z*SPT_W +: SPT_W];
        assign skew_a[z]  = ZONE_SKEW[z*SKEW_W +: SKEW_W];
        if (z == NUM_ZONES - 1) begin : g_last
            assign end_a[z] = (CYL_W+1)'(TOTAL_CYLS);
        end else begin : g_mid
            assign end_a[z] = {1'b0, ZONE_START[(z+1)*CYL_W +: CYL_W]};
        end
        assign size_a[z] = (LBA_W+1)'((end_a[z] - {1'b0, start_a[z]})
                         * (LBA_W+1)'(spt_a[z]) * (LBA_W+1)'(HEADS));
    end

    always_comb begin
        z_start = '0;
        z_spt   = '0;
        z_skew  = '0;
        z_size  = '0;
        if (int'(idx) < NUM_ZONES) begin
            z_start = start_a[idx];
            z_spt   = spt_a[idx];
            z_skew  = skew_a[idx];
            z_size  = size_a[idx];
        end
    end

endmodule

// File: rtl/xlat_serial_div.sv
module xlat_serial_div #(
    parameter int DW = 16,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [SW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic [SW-1:0] remainder,
    output logic          done
);

    localparam int CW = $clog2(DW + 1);
    localparam int PW = DW + SW;

    logic [DW-1:0] quo_q, dvd_q;
    logic [SW-1:0] rem_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [SW:0]   trial;
    logic          fits;

    assign trial = {rem_q, quo_q[DW-1]};
    assign fits  = (trial >= {1'b0, dvs_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            dvd_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quo_q  <= dividend;
                dvd_q  <= dividend;
                dvs_q  <= divisor;
                rem_q  <= '0;
                cnt_q  <= CW'(DW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= SW'(trial - {1'b0, dvs_q});
                    quo_q <= {quo_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= trial[SW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;

    // R6
    div_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem_q < dvs_q));

    // R4
    div_identity_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (PW'(quo_q) * PW'(dvs_q) + PW'(rem_q) == PW'(dvd_q)));

endmodule

// File: rtl/xlat_remap_store.sv
module xlat_remap_store
    import lba_xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int RI_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [RI_W-1:0]  widx,
    input  logic             wen,
    input  logic [LBA_W-1:0] wlba,
    input  chs_t             wchs,
    input  logic [LBA_W-1:0] key,
    output logic             hit,
    output chs_t             hit_chs
);

    logic             en_a  [ENTRIES];
    logic [LBA_W-1:0] lba_a [ENTRIES];
    chs_t             chs_a [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                en_a[i]  <= 1'b0;
                lba_a[i] <= '0;
                chs_a[i] <= '0;
            end
        end else if (we && int'(widx) < ENTRIES) begin
            en_a[widx]  <= wen;
            lba_a[widx] <= wlba;
            chs_a[widx] <= wchs;
        end
    end

    // Scan from the top so the lowest matching index is the one kept.
    always_comb begin
        hit     = 1'b0;
        hit_chs = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (en_a[i] && lba_a[i] == key) begin
                hit     = 1'b1;
                hit_chs = chs_a[i];
            end
        end
    end

    // R7
    remap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !wen && int'(widx) < ENTRIES) |=> !en_a[$past(widx)]);

endmodule

// File: rtl/lba_xlat.sv
module lba_xlat
    import lba_xlat_pkg::*;
#(
    parameter int NUM_ZONES  = 4,
    parameter int TOTAL_CYLS = 16,
    parameter logic [NUM_ZONES*CYL_W-1:0]  ZONE_START = {8'd12, 8'd8, 8'd4, 8'd0},
    parameter logic [NUM_ZONES*SPT_W-1:0]  ZONE_SPT   = {6'd6, 6'd8, 6'd10, 6'd12},
    parameter logic [NUM_ZONES*SKEW_W-1:0] ZONE_SKEW  = {4'd1, 4'd2, 4'd2, 4'd3},
    parameter logic [SKEW_W-1:0] HEAD_SKEW = 4'd1,
    parameter int NUM_SLIP = 2,
    parameter logic [NUM_SLIP*LBA_W-1:0] SLIP_POS = {16'd100, 16'd5},
    parameter int REMAP_N = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [LBA_W-1:0]           req_lba,
    output logic                       rsp_valid,
    output logic                       rsp_err,
    output logic [CYL_W-1:0]           rsp_cyl,
    output logic [HEAD_W-1:0]          rsp_head,
    output logic [SPT_W-1:0]           rsp_slot,
    input  logic                       remap_we,
    input  logic [$clog2(REMAP_N)-1:0] remap_idx,
    input  logic                       remap_en,
    input  logic [LBA_W-1:0]           remap_lba,
    input  logic [CYL_W-1:0]           remap_cyl,
    input  logic [HEAD_W-1:0]          remap_head,
    input  logic [SPT_W-1:0]           remap_slot
);

    localparam int HEADS  = 1 << HEAD_W;
    localparam int CAP_W  = LBA_W + 1;
    localparam int ZI_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1;
    localparam int SK_W   = $clog2(NUM_SLIP + 1);

    function automatic logic [CAP_W-1:0] phys_total();
        logic [CAP_W-1:0] acc;
        int e;
        acc = '0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (z == NUM_ZONES - 1) e = TOTAL_CYLS;
            else e = int'(ZONE_START[(z+1)*CYL_W +: CYL_W]);
            acc = acc + CAP_W'((e - int'(ZONE_START[z*CYL_W +: CYL_W]))
                * int'(ZONE_SPT[z*SPT_W +: SPT_W]) * HEADS);
        end
        return acc;
    endfunction

    localparam logic [CAP_W-1:0] LOGICAL_CAP = phys_total() - CAP_W'(NUM_SLIP);

    xlat_state_e       state_q;
    logic [LBA_W-1:0]  lba_q;
    logic [LBA_W-1:0]  phys_q;
    logic [SK_W-1:0]   slip_k_q;
    logic [ZI_W-1:0]   zidx_q;
    logic [CAP_W-1:0]  base_q;
    logic              err_q;
    logic              remapped_q;
    chs_t              res_q;

    logic              div_start_q;
    logic [DIV_W-1:0]  div_a_q;
    logic [SPT_W-1:0]  div_b_q;
    logic [DIV_W-1:0]  div_q;
    logic [SPT_W-1:0]  div_r;
    logic              div_done;

    logic [CYL_W-1:0]  z_start;
    logic [SPT_W-1:0]  z_spt;
    logic [SKEW_W-1:0] z_skew;
    logic [CAP_W-1:0]  z_size;

    logic              rm_hit;
    chs_t              rm_chs;
    chs_t              wr_chs;

    logic [LBA_W-1:0]  slip_a [NUM_SLIP + 1];
    logic [LBA_W-1:0]  slip_cur;
    logic [CYL_W-1:0]  trk_cyl;
    logic [HEAD_W-1:0] trk_head;

    for (genvar s = 0; s < NUM_SLIP; s++) begin : g_slip
        assign slip_a[s] = SLIP_POS[s*LBA_W +: LBA_W];
    end
    assign slip_a[NUM_SLIP] = '1;
    assign slip_cur = slip_a[slip_k_q];

    assign trk_cyl  = z_start + CYL_W'(div_q >> HEAD_W);
    assign trk_head = div_q[HEAD_W-1:0];

    assign wr_chs = '{cyl: remap_cyl, head: remap_head, slot: remap_slot};

    xlat_zone_table #(
        .NUM_ZONES (NUM_ZONES),
        .TOTAL_CYLS(TOTAL_CYLS),
        .ZONE_START(ZONE_START),
        .ZONE_SPT  (ZONE_SPT),
        .ZONE_SKEW (ZONE_SKEW)
    ) i_zone (
        .idx    (zidx_q),
        .z_start(z_start),
        .z_spt  (z_spt),
        .z_skew (z_skew),
        .z_size (z_size)
    );

    xlat_serial_div #(
        .DW(DIV_W),
        .SW(SPT_W)
    ) i_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start_q),
        .dividend (div_a_q),
        .divisor  (div_b_q),
        .quotient (div_q),
        .remainder(div_r),
        .done     (div_done)
    );

    xlat_remap_store #(
        .ENTRIES(REMAP_N)
    ) i_remap (
        .clk    (clk),
        .rst    (rst),
        .we     (remap_we),
        .widx   (remap_idx),
        .wen    (remap_en),
        .wlba   (remap_lba),
        .wchs   (wr_chs),
        .key    (lba_q),
        .hit    (rm_hit),
        .hit_chs(rm_chs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lba_q       <= '0;
            phys_q      <= '0;
            slip_k_q    <= '0;
            zidx_q      <= '0;
            base_q      <= '0;
            err_q       <= 1'b0;
            remapped_q  <= 1'b0;
            res_q       <= '0;
            div_start_q <= 1'b0;
            div_a_q     <= '0;
            div_b_q     <= '0;
        end else begin
            div_start_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lba_q      <= req_lba;
                        err_q      <= 1'b0;
                        remapped_q <= 1'b0;
                        state_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if ({1'b0, lba_q} >= LOGICAL_CAP) begin
                        err_q   <= 1'b1;
                        res_q   <= '0;
                        state_q <= ST_DONE;
                    end else if (rm_hit) begin
                        remapped_q <= 1'b1;
                        res_q      <= rm_chs;
                        state_q    <= ST_DONE;
                    end else begin
                        phys_q   <= lba_q;
                        slip_k_q <= '0;
                        state_q  <= ST_SLIP;
                    end
                end
                ST_SLIP: begin
                    if (int'(slip_k_q) == NUM_SLIP) begin
                        zidx_q  <= '0;
                        base_q  <= '0;
                        state_q <= ST_ZONE;
                    end else begin
                        if (slip_cur <= phys_q) phys_q <= phys_q + LBA_W'(1);
                        slip_k_q <= slip_k_q + SK_W'(1);
                    end
                end
                ST_ZONE: begin
                    if ({1'b0, phys_q} < base_q + z_size) begin
                        div_a_q     <= DIV_W'({1'b0, phys_q} - base_q);
                        div_b_q     <= z_spt;
                        div_start_q <= 1'b1;
                        state_q     <= ST_DIV_TRK;
                    end else if (int'(zidx_q) == NUM_ZONES - 1) begin
                        err_q   <= 1'b1;
                        res_q   <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        base_q <= base_q + z_size;
                        zidx_q <= zidx_q + ZI_W'(1);
                    end
                end
                ST_DIV_TRK: begin
                    if (div_done) begin
                        res_q.cyl   <= trk_cyl;
                        res_q.head  <= trk_head;
                        div_a_q     <= skewed_pos(div_r, trk_cyl, z_skew,
                                                  trk_head, HEAD_SKEW);
                        div_start_q <= 1'b1;
                        state_q     <= ST_DIV_SLOT;
                    end
                end
                ST_DIV_SLOT: begin
                    if (div_done) begin
                        res_q.slot <= div_r;
                        state_q    <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_DONE);
    assign rsp_err   = err_q;
    assign rsp_cyl   = res_q.cyl;
    assign rsp_head  = res_q.head;
    assign rsp_slot  = res_q.slot;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid));

    // R2
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    err_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_cyl == '0 && rsp_head == '0 && rsp_slot == '0));

    // R8
    in_range_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> ({1'b0, lba_q} < LOGICAL_CAP));

    // R5
    slip_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ZONE) |-> (phys_q >= lba_q && int'(phys_q - lba_q) <= NUM_SLIP));

    // R4
    inside_zone_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && !remapped_q) |->
            (rsp_cyl >= z_start && int'(rsp_cyl) < TOTAL_CYLS && rsp_slot < z_spt));

endmodule

// File: tb/test_lba_xlat.sv
module test_lba_xlat;
    import lba_xlat_pkg::*;

    localparam int CAP      = 286;
    localparam int PHYS_ALL = 288;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LBA_W-1:0]  req_lba = '0;
    logic              rsp_valid, rsp_err;
    logic [CYL_W-1:0]  rsp_cyl;
    logic [HEAD_W-1:0] rsp_head;
    logic [SPT_W-1:0]  rsp_slot;
    logic              remap_we = 1'b0;
    logic [3:0]        remap_idx = '0;
    logic              remap_en = 1'b0;
    logic [LBA_W-1:0]  remap_lba = '0;
    logic [CYL_W-1:0]  remap_cyl = '0;
    logic [HEAD_W-1:0] remap_head = '0;
    logic [SPT_W-1:0]  remap_slot = '0;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    int m_en [16];
    int m_lba[16];
    int m_cyl[16];
    int m_hd [16];
    int m_sl [16];

    always #4 clk = ~clk;

    lba_xlat i_lba_xlat (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_lba(req_lba),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cyl(rsp_cyl),
        .rsp_head(rsp_head), .rsp_slot(rsp_slot),
        .remap_we(remap_we), .remap_idx(remap_idx), .remap_en(remap_en),
        .remap_lba(remap_lba), .remap_cyl(remap_cyl), .remap_head(remap_head),
        .remap_slot(remap_slot)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_vec = n_vec + 1;
            n_bad = n_bad + 1;
            $display("FAIL R2 watchdog: got no completion, expected end of run");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int pack(input int e, input int c, input int h, input int s);
        return (e << 24) | (c << 12) | (h << 8) | s;
    endfunction

    // Arithmetic model of the requirements.
    function automatic int model(input int lba);
        int zs[4];
        int sp[4];
        int sk[4];
        int p, cnt, base, ze, size, off, trk, sec, cyl, hd;
        zs = '{0, 4, 8, 12};
        sp = '{12, 10, 8, 6};
        sk = '{3, 2, 2, 1};
        if (lba >= CAP) return pack(1, 0, 0, 0);
        for (int i = 0; i < 16; i++)
            if (m_en[i] != 0 && m_lba[i] == lba)
                return pack(0, m_cyl[i], m_hd[i], m_sl[i]);
        p = -1;
        cnt = 0;
        for (int q = 0; q < PHYS_ALL; q++) begin
            if (q != 5 && q != 100) begin
                if (cnt == lba && p < 0) p = q;
                cnt++;
            end
        end
        base = 0;
        for (int z = 0; z < 4; z++) begin
            ze = (z == 3) ? 16 : zs[z+1];
            size = (ze - zs[z]) * sp[z] * 2;
            if (p < base + size) begin
                off = p - base;
                trk = off / sp[z];
                sec = off % sp[z];
                cyl = zs[z] + trk / 2;
                hd  = trk % 2;
                return pack(0, cyl, hd, (sec + cyl * sk[z] + hd) % sp[z]);
            end
            base += size;
        end
        return pack(1, 0, 0, 0);
    endfunction

    task automatic request(input int lba, input bit hs, output int got);
        int guard;
        @(negedge clk);
        req_valid = 1'b1;
        req_lba   = LBA_W'(lba);
        @(negedge clk);
        req_valid = 1'b0;
        if (hs) check("R2 ready low while busy", int'(req_ready), 0);
        guard = 0;
        while (!rsp_valid && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        got = pack(int'(rsp_err), int'(rsp_cyl), int'(rsp_head), int'(rsp_slot));
        if (hs) begin
            check("R2 response seen", int'(rsp_valid), 1);
            @(negedge clk);
            check("R2 single pulse", int'(rsp_valid), 0);
            check("R2 ready after response", int'(req_ready), 1);
        end
    endtask

    task automatic xlat_check(input string tag, input int lba);
        int got;
        request(lba, 1'b0, got);
        check($sformatf("%s lba %0d", tag, lba), got, model(lba));
    endtask

    task automatic write_remap(input int idx, input int en, input int lba,
                               input int c, input int h, input int s);
        @(negedge clk);
        remap_we   = 1'b1;
        remap_idx  = 4'(idx);
        remap_en   = 1'(en);
        remap_lba  = LBA_W'(lba);
        remap_cyl  = CYL_W'(c);
        remap_head = HEAD_W'(h);
        remap_slot = SPT_W'(s);
        @(negedge clk);
        remap_we = 1'b0;
        m_en[idx] = en; m_lba[idx] = lba; m_cyl[idx] = c; m_hd[idx] = h; m_sl[idx] = s;
    endtask

    initial begin
        int got;
        for (int i = 0; i < 16; i++) begin
            m_en[i] = 0; m_lba[i] = 0; m_cyl[i] = 0; m_hd[i] = 0; m_sl[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 no response after reset", int'(rsp_valid), 0);

        // R2 handshake on one request
        request(0, 1'b1, got);
        check("R2 lba 0", got, model(0));

        // R5 slip boundary: lba 5 lands on physical 6
        xlat_check("R5 before slip", 4);
        xlat_check("R5 after slip", 5);
        check("R5 lba 5 explicit", model(5), pack(0, 0, 0, 6));
        // R4 zone edge: physical 95 / 96
        xlat_check("R4 zone0 last", 94);
        xlat_check("R4 zone1 first", 95);
        check("R4 zone1 first explicit", model(95), pack(0, 4, 0, 8));
        // R6 head skew on a head-1 track
        xlat_check("R6 head one", 11);

        // Full sweep past capacity
        for (int l = 0; l < CAP + 3; l++) begin
            if (l >= CAP) xlat_check("R3", l);
            else xlat_check("R4 R5 R6", l);
        end

        // R7 remap: duplicates, lowest index wins
        write_remap(3, 1, 7, 15, 1, 5);
        xlat_check("R7 single entry", 7);
        check("R7 single explicit", model(7), pack(0, 15, 1, 5));
        write_remap(0, 1, 7, 14, 0, 2);
        xlat_check("R7 lowest index wins", 7);
        check("R7 priority explicit", model(7), pack(0, 14, 0, 2));
        xlat_check("R7 neighbour unaffected", 8);
        write_remap(5, 1, CAP - 1, 1, 1, 1);
        xlat_check("R7 last address remapped", CAP - 1);
        // R8 out-of-range with a matching entry still errors
        write_remap(1, 1, CAP + 1, 2, 0, 3);
        xlat_check("R8 error beats remap", CAP + 1);
        // R7 removal
        write_remap(0, 0, 7, 0, 0, 0);
        xlat_check("R7 after clearing idx0", 7);
        write_remap(3, 0, 7, 0, 0, 0);
        xlat_check("R7 after clearing all", 7);
        check("R7 cleared explicit", model(7), model(6) + 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule